// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block walks the element and sub-element positions of one vector instruction. Its source side and its destination side each hold an element counter (0 to VL-1) and a sub-element counter (0 to SUBVL-1). Each side moves one position per accepted request. The nesting of the two loops is chosen per side: the sub-element loop is inner by default, and a per-side invert flag makes the element loop inner instead.

In horizontal mode each side moves on its own issue request. In vertical-first mode issue requests are ignored, and both sides move together only on an explicit step command. A batch-size hint splits the element range into groups of that many elements. In vertical-first mode the block raises a group-stop flag while either side sits on the last element of its group, so that issue can halt there. An end-of-loop flag marks the final position of both sides. The loop configuration may only change while the restart input is high.

Top module: `vstep_seq`

## Requirements
- R1: After reset, and one cycle after `restart` is high, all four counters read zero.
- R2: With `packEn` low, the source sub-element counter is the inner loop. `subCode` values 0, 1, 2 and 3 select 1, 2, 3 and 4 sub-elements. After k steps, srcIdx = k / SUBVL and srcSub = k mod SUBVL.
- R3: With `packEn` high, the source element counter is the inner loop. After k steps, srcIdx = k mod VL and srcSub = k / VL.
- R4: `unpackEn` selects the destination nesting order in the same way: low gives dstIdx = k / SUBVL and dstSub = k mod SUBVL; high gives dstIdx = k mod VL and dstSub = k / VL.
- R5: With `vertFirst` low, the source side moves one step per cycle with `advSrc` high and the destination side moves one step per cycle with `advDst` high. The two sides move independently, and `stepCmd` has no effect.
- R6: With `vertFirst` high, `advSrc` and `advDst` have no effect. Each cycle with `stepCmd` high moves both sides one step.
- R7: For a nonzero hint H, an element idx ends its batch when idx mod H = H-1 or idx = VL-1. `groupStop` is high exactly when `vertFirst` is high, H is nonzero, and srcIdx or dstIdx ends its batch.
- R8: A hint of zero keeps `groupStop` low. A hint larger than VL forms a single batch whose only end is element VL-1.
- R9: `loopDone` is high exactly when both sides are at element VL-1 and sub-element SUBVL-1. A step taken from that final position returns the side to element 0, sub-element 0.
- R10: With VL zero, `loopDone` stays high and the counters stay at zero whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clears all counters at the next edge; the configuration may change only while it is high |
| vecLen | input | 7 | Vector length VL, from 0 to 127 |
| subCode | input | 2 | Sub-vector length minus one |
| packEn | input | 1 | Makes the source element loop the inner loop |
| unpackEn | input | 1 | Makes the destination element loop the inner loop |
| vertFirst | input | 1 | Vertical-first mode |
| batchHint | input | 7 | Batch size hint; 0 means no hint |
| advSrc | input | 1 | Source issue request (horizontal mode) |
| advDst | input | 1 | Destination issue request (horizontal mode) |
| stepCmd | input | 1 | Explicit step of both sides (vertical-first mode) |
| srcIdx | output | 7 | Source element counter |
| srcSub | output | 2 | Source sub-element counter |
| dstIdx | output | 7 | Destination element counter |
| dstSub | output | 2 | Destination sub-element counter |
| loopDone | output | 1 | Both sides are at their final position |
| groupStop | output | 1 | Horizontal issue must stop at the current element |

## Verification
The counters are registers: a request or step sampled at one rising edge shows up in the indices at that edge. `loopDone` and `groupStop` are decoded from the registered indices and follow them in the same cycle. The bench drives its inputs just after a falling edge and reads every output at the following falling edge. It advances its arithmetic step counts by the requests it applied. Each reading is therefore compared with the position reached after exactly the requests accepted so far, one edge later.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int DEF_ELEM_W = 7;
  localparam int DEF_SUB_W  = 2;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic clr;
    logic srcInc;
    logic dstInc;
  } stepStrobe_t;
endpackage

// File: rtl/vstep_chan.sv
module vstep_chan #(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              inc,
  input  logic              invert,
  input  logic [ELEM_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subMax,
  input  logic [ELEM_W-1:0] batchHint,
  output logic [ELEM_W-1:0] idx,
  output logic [SUB_W-1:0]  sub,
  output logic              chanLast,
  output logic              batchEnd
);
  localparam int CW = ELEM_W + 1;

  logic [ELEM_W-1:0] pos;
  logic elemLast, subLast, posLast, hintOn;

  assign elemLast = (CW'(idx) + CW'(1)) == CW'(vecLen);
  assign subLast  = (sub == subMax);
  assign hintOn   = (batchHint != '0);
  assign posLast  = hintOn && ((CW'(pos) + CW'(1)) == CW'(batchHint));
  assign chanLast = (vecLen == '0) || (elemLast && subLast);
  assign batchEnd = elemLast || posLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
      sub <= '0;
      pos <= '0;
    end else if (clr) begin
      idx <= '0;
      sub <= '0;
      pos <= '0;
    end else if (inc) begin
      if (!invert) begin
        if (subLast) begin
          sub <= '0;
          idx <= elemLast ? '0 : idx + ELEM_W'(1);
          pos <= (elemLast || posLast) ? '0 : pos + ELEM_W'(1);
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end else begin
        idx <= elemLast ? '0 : idx + ELEM_W'(1);
        pos <= (elemLast || posLast) ? '0 : pos + ELEM_W'(1);
        if (elemLast) sub <= subLast ? '0 : sub + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/vstep_path.sv
module vstep_path
  import vstep_pkg::*;
#(
  parameter int ELEM_W = DEF_ELEM_W,
  parameter int SUB_W  = DEF_SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobe_t       strobe,
  input  logic              packEn,
  input  logic              unpackEn,
  input  logic [ELEM_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subCode,
  input  logic [ELEM_W-1:0] batchHint,
  output logic [ELEM_W-1:0] srcIdx,
  output logic [SUB_W-1:0]  srcSub,
  output logic [ELEM_W-1:0] dstIdx,
  output logic [SUB_W-1:0]  dstSub,
  output logic [1:0]        chanLast,
  output logic [1:0]        batchEnd
);
  logic [ELEM_W-1:0] idxArr [2];
  logic [SUB_W-1:0]  subArr [2];
  logic [1:0]        incArr, invArr;

  assign incArr = {strobe.dstInc, strobe.srcInc};
  assign invArr = {unpackEn, packEn};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    vstep_chan #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (strobe.clr),
      .inc      (incArr[ch]),
      .invert   (invArr[ch]),
      .vecLen   (vecLen),
      .subMax   (subCode),
      .batchHint(batchHint),
      .idx      (idxArr[ch]),
      .sub      (subArr[ch]),
      .chanLast (chanLast[ch]),
      .batchEnd (batchEnd[ch])
    );
  end

  assign srcIdx = idxArr[0];
  assign srcSub = subArr[0];
  assign dstIdx = idxArr[1];
  assign dstSub = subArr[1];
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int ELEM_W = DEF_ELEM_W
) (
  input  logic              restart,
  input  logic              vertFirst,
  input  logic [ELEM_W-1:0] vecLen,
  input  logic [ELEM_W-1:0] batchHint,
  input  logic              advSrc,
  input  logic              advDst,
  input  logic              stepCmd,
  input  logic [1:0]        chanLast,
  input  logic [1:0]        batchEnd,
  output stepStrobe_t       strobe,
  output logic              loopDone,
  output logic              groupStop
);
  logic live;

  assign live = (vecLen != '0) && !restart;

  always_comb begin
    strobe.clr    = restart;
    strobe.srcInc = live && (vertFirst ? stepCmd : advSrc);
    strobe.dstInc = live && (vertFirst ? stepCmd : advDst);
  end

  assign loopDone  = &chanLast;
  assign groupStop = vertFirst && (batchHint != '0) && (|batchEnd);
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
  import vstep_pkg::*;
#(
  parameter int ELEM_W = DEF_ELEM_W,
  parameter int SUB_W  = DEF_SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic [ELEM_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subCode,
  input  logic              packEn,
  input  logic              unpackEn,
  input  logic              vertFirst,
  input  logic [ELEM_W-1:0] batchHint,
  input  logic              advSrc,
  input  logic              advDst,
  input  logic              stepCmd,
  output logic [ELEM_W-1:0] srcIdx,
  output logic [SUB_W-1:0]  srcSub,
  output logic [ELEM_W-1:0] dstIdx,
  output logic [SUB_W-1:0]  dstSub,
  output logic              loopDone,
  output logic              groupStop
);
  stepStrobe_t strobe;
  logic [1:0]  chanLast, batchEnd;

  vstep_ctrl #(.ELEM_W(ELEM_W)) u_ctrl (
    .restart  (restart),
    .vertFirst(vertFirst),
    .vecLen   (vecLen),
    .batchHint(batchHint),
    .advSrc   (advSrc),
    .advDst   (advDst),
    .stepCmd  (stepCmd),
    .chanLast (chanLast),
    .batchEnd (batchEnd),
    .strobe   (strobe),
    .loopDone (loopDone),
    .groupStop(groupStop)
  );

  vstep_path #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .packEn   (packEn),
    .unpackEn (unpackEn),
    .vecLen   (vecLen),
    .subCode  (subCode),
    .batchHint(batchHint),
    .srcIdx   (srcIdx),
    .srcSub   (srcSub),
    .dstIdx   (dstIdx),
    .dstSub   (dstSub),
    .chanLast (chanLast),
    .batchEnd (batchEnd)
  );
endmodule

// File: rtl/vstep_seq_chk.sv
module vstep_seq_chk #(
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              restart,
  input logic [ELEM_W-1:0] vecLen,
  input logic [SUB_W-1:0]  subCode,
  input logic              packEn,
  input logic              unpackEn,
  input logic              vertFirst,
  input logic [ELEM_W-1:0] batchHint,
  input logic              advSrc,
  input logic              advDst,
  input logic              stepCmd,
  input logic [ELEM_W-1:0] srcIdx,
  input logic [SUB_W-1:0]  srcSub,
  input logic [ELEM_W-1:0] dstIdx,
  input logic [SUB_W-1:0]  dstSub,
  input logic              loopDone,
  input logic              groupStop
);
  p_restart_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (srcIdx == '0 && srcSub == '0 && dstIdx == '0 && dstSub == '0));

  p_sub_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    !restart |-> (srcSub <= subCode && dstSub <= subCode));

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && vecLen != '0) |-> (srcIdx < vecLen && dstIdx < vecLen));

  p_vfirst_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vertFirst && !stepCmd && !restart) |=>
      ($stable(srcIdx) && $stable(srcSub) && $stable(dstIdx) && $stable(dstSub)));

  p_stop_needs_hint_r8: assert property (@(posedge clk) disable iff (!rstN)
    groupStop |-> (vertFirst && batchHint != '0));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!vertFirst && advSrc && advDst && loopDone && !restart && vecLen != '0) |=>
      (srcIdx == '0 && srcSub == '0 && dstIdx == '0 && dstSub == '0));

  p_empty_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (vecLen == '0) |-> loopDone);
endmodule

bind vstep_seq vstep_seq_chk #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_chk (.*);

// File: tb/vstep_seq_test.sv
module vstep_seq_test;
  logic       clk = 1'b0;
  logic       rstN, restart, packEn, unpackEn, vertFirst;
  logic       advSrc, advDst, stepCmd;
  logic [6:0] vecLen, batchHint;
  logic [1:0] subCode;
  logic [6:0] srcIdx, dstIdx;
  logic [1:0] srcSub, dstSub;
  logic       loopDone, groupStop;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vstep_seq uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eIdx(int k, int vl, int sv, bit inv);
    if (vl == 0) return 0;
    return inv ? (k % vl) : (k / sv);
  endfunction

  function automatic int eSub(int k, int vl, int sv, bit inv);
    if (vl == 0) return 0;
    return inv ? (k / vl) : (k % sv);
  endfunction

  function automatic bit eEnd(int idx, int vl, int h);
    return (idx == vl - 1) || (h != 0 && (idx % h) == h - 1);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int vls[4]   = '{0, 1, 3, 5};
    int hints[5] = '{0, 1, 2, 3, 8};
    rstN = 1'b0; restart = 1'b0; packEn = 1'b0; unpackEn = 1'b0; vertFirst = 1'b0;
    advSrc = 1'b0; advDst = 1'b0; stepCmd = 1'b0;
    vecLen = 7'd4; batchHint = 7'd0; subCode = 2'd1;
    repeat (3) @(negedge clk);
    chk(srcIdx == 0 && srcSub == 0 && dstIdx == 0 && dstSub == 0, "R1", "reset zero",
        int'(srcIdx) + int'(srcSub) + int'(dstIdx) + int'(dstSub), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int vi = 0; vi < 4; vi++) begin
      for (int sc = 0; sc < 4; sc++) begin
        for (int pm = 0; pm < 4; pm++) begin
          for (int md = 0; md < 6; md++) begin
            int vl    = vls[vi];
            int sv    = sc + 1;
            int total = vl * sv;
            bit vf    = (md != 0);
            int h     = vf ? hints[md - 1] : 3;
            bit pk    = pm[0];
            bit up    = pm[1];
            int kS = 0;
            int kD = 0;
            string tS, tD, tL, tG;
            restart = 1'b1; vecLen = 7'(vl); subCode = 2'(sc); packEn = pk; unpackEn = up;
            vertFirst = vf; batchHint = 7'(h); advSrc = 1'b1; advDst = 1'b1; stepCmd = 1'b1;
            @(negedge clk);
            chk(srcIdx == 0 && srcSub == 0 && dstIdx == 0 && dstSub == 0, "R1", "restart zero",
                int'(srcIdx) + int'(srcSub) + int'(dstIdx) + int'(dstSub), 0);
            restart = 1'b0;
            tS = vf ? "R6" : (pk ? "R3" : "R2");
            tD = vf ? "R6" : (up ? "R4" : "R5");
            tL = (vl == 0) ? "R10" : "R9";
            tG = (h == 0 || h > vl) ? "R8" : "R7";
            for (int n = 0; n < 2 * total + 4; n++) begin
              int si = eIdx(kS, vl, sv, pk);
              int di = eIdx(kD, vl, sv, up);
              bit expDone = (vl == 0) || (kS == total - 1 && kD == total - 1);
              bit expStop = vf && h != 0 && (eEnd(si, vl, h) || eEnd(di, vl, h));
              bit aS, aD, st;
              chk(int'(srcIdx) == si, tS, "srcIdx", srcIdx, si);
              chk(int'(srcSub) == eSub(kS, vl, sv, pk), tS, "srcSub", srcSub, eSub(kS, vl, sv, pk));
              chk(int'(dstIdx) == di, tD, "dstIdx", dstIdx, di);
              chk(int'(dstSub) == eSub(kD, vl, sv, up), tD, "dstSub", dstSub, eSub(kD, vl, sv, up));
              chk(loopDone == expDone, tL, "loopDone", loopDone, expDone);
              chk(groupStop == expStop, tG, "groupStop", groupStop, expStop);
              aS = vf ? 1'b1 : ((n % 5) != 4);
              aD = vf ? 1'b1 : ((n % 3) != 2);
              st = vf ? ((n % 2) == 0) : ((n % 2) == 1);
              advSrc = aS; advDst = aD; stepCmd = st;
              @(negedge clk);
              if (vl != 0) begin
                if (vf) begin
                  if (st) begin kS = (kS + 1) % total; kD = (kD + 1) % total; end
                end else begin
                  if (aS) kS = (kS + 1) % total;
                  if (aD) kD = (kD + 1) % total;
                end
              end
            end
          end
        end
      end
    end
    finished = 1'b1;
    summary();
  end
endmodule